// File: doc/BRIEF.md
# Twin-Masked Element Pair Sequencer

This block walks a one-source, one-destination vector operation and emits the stream of (source element, destination element) index pairs that the operation must process. Each side has its own mask, its own zeroing switch and its own scalar switch. Both the source position and the destination position move forward on their own, and each jumps over its own disabled elements. As a result, the k-th enabled source element is paired with the k-th enabled destination element. Compress, expand, compress-then-expand, splat, extract and insert all come from the same hardware. Which one happens depends only on the masks and the scalar switches. A single-element mask, such as one built by shifting 1 left by a register value, selects one element.

A `start` pulse while idle captures the vector length, both masks and both mode pairs. From the next cycle on, the block presents one pair at a time under a valid/ready handshake. A combinational lowest-set-bit search finds each side's next enabled element in a single cycle. When either side runs out, `done` pulses for one cycle and the block goes idle. The block does not perform the element operation, touch registers or generate addresses. It only produces indices and two flags: one for a source that reads as zero and one for a destination that must be written with zero.

Top module: `tpseq_step_seq`

## Requirements
- R1: After reset, `out_valid` and `done` are low. A `start` seen while idle captures the configuration, and the block answers in the very next cycle with either a pair (`out_valid`) or `done`.
- R2: A vector source without zeroing presents only the source indices whose `src_mask` bit is 1 and whose index is below the vector length, in strictly ascending order, with `src_null` low.
- R3: A vector destination without zeroing presents only the destination indices whose `dst_mask` bit is 1 and whose index is below the vector length, in strictly ascending order, with `zero_wr` low.
- R4: The n-th pair carries the n-th source element together with the n-th destination element. The number of pairs issued equals the smaller of the two sides' element counts.
- R5: A side with zeroing set visits every index from 0 up to the vector length minus 1, disabled ones included. A disabled source position raises `src_null`, and a disabled destination position raises `zero_wr`. With zeroing on both sides, the two indices are equal in every pair.
- R6: With `src_scalar` set, every pair has source index 0 and `src_null` low, whatever `src_mask` holds. Pairs continue until the destination side is exhausted (splat, insert).
- R7: With `dst_scalar` set, exactly one pair is issued if the vector length is nonzero and the source side has an element. That pair has destination index 0, whatever `dst_mask` holds (extract).
- R8: `done` is high for exactly one cycle, in the first cycle in which either side has no element left. It is never high together with `out_valid`. A vector length of 0, or an all-zero mask on a vector side without zeroing, gives `done` with no pair.
- R9: While `out_valid` is high and `out_ready` is low, the same pair is held unchanged in the following cycle.
- R10: A `start` pulse while busy has no effect, and input changes while busy have no effect. A vector length above the element count N is treated as N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sequence (honoured only when idle) |
| vl | input | $clog2(N+1) | Vector length, clamped to N |
| src_mask | input | N | Source element enables, bit i for element i |
| dst_mask | input | N | Destination element enables, bit i for element i |
| src_zero | input | 1 | Source zeroing: step through disabled source elements |
| dst_zero | input | 1 | Destination zeroing: step through disabled destination elements |
| src_scalar | input | 1 | Source is a single element at index 0 |
| dst_scalar | input | 1 | Destination is a single element at index 0 |
| out_ready | input | 1 | Consumer accepts the presented pair |
| out_valid | output | 1 | A pair is presented |
| src_idx | output | $clog2(N) | Source element index of the pair |
| dst_idx | output | $clog2(N) | Destination element index of the pair |
| src_null | output | 1 | Source element is disabled and reads as zero |
| zero_wr | output | 1 | Destination element is disabled and must be written with zero |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
Two functions can meet in the same clock edge. The first is the handshake that accepts the last pair. The second is the exhaustion test that raises `done`. The accepted pair moves a position past its last element, so the exhaustion test must see the updated positions in the next cycle and nowhere else. The bench provokes this boundary constantly. It sweeps every pair of 4-bit masks under all sixteen zeroing/scalar combinations while a pseudo-random `out_ready` stalls some last pairs and accepts others at once. It also pulses `start` and scrambles the inputs while busy. At `done`, the bench judges the number of accepted pairs against an arithmetic model of both sides' element lists. The checker requires that `done` never coincides with `out_valid` and never lasts two cycles.

// File: rtl/tpseq_pkg.sv
package tpseq_pkg;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    // Per-side mode captured at start
    typedef struct packed {
        logic zero;    // step through disabled elements
        logic scalar;  // single element at index 0
    } side_mode_t;

    // Per-side result of the element search for the current cycle
    typedef struct packed {
        logic exhausted;   // no element left on this side
        logic masked_off;  // current element disabled (zeroing only)
    } side_stat_t;

endpackage

// File: rtl/tpseq_lowbit.sv
// Lowest-set-bit priority encoder.
module tpseq_lowbit #(
    parameter  int N  = 8,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);

    always_comb begin
        found = |req;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end

endmodule

// File: rtl/tpseq_side_scan.sv
// Finds one side's element for the current cycle and its successor position.
module tpseq_side_scan
    import tpseq_pkg::*;
#(
    parameter  int N      = 8,
    parameter  bit IS_DST = 1'b0,
    localparam int IW     = $clog2(N),
    localparam int CW     = $clog2(N + 1)
) (
    input  logic [N-1:0]  mask,
    input  logic [CW-1:0] vlen,
    input  logic [CW-1:0] pos,
    input  side_mode_t    mode,
    output side_stat_t    stat,
    output logic [IW-1:0] sel,
    output logic [CW-1:0] nxt
);

    logic [N-1:0]  elig;
    logic          any_elig;
    logic [IW-1:0] low_idx;

    // Enabled, not yet passed, and inside the vector length
    for (genvar g = 0; g < N; g++) begin : g_elig
        localparam logic [CW-1:0] GI = CW'(g);
        assign elig[g] = mask[g] && (GI >= pos) && (GI < vlen);
    end

    tpseq_lowbit #(.N(N)) u_pe (
        .req   (elig),
        .found (any_elig),
        .idx   (low_idx)
    );

    always_comb begin
        stat = '0;
        sel  = '0;
        nxt  = pos;
        if (vlen == '0) begin
            stat.exhausted = 1'b1;
        end else if (mode.scalar) begin
            // source: endless supply of element 0; destination: one slot only
            stat.exhausted = IS_DST ? (pos != '0) : 1'b0;
            nxt            = IS_DST ? CW'(1) : '0;
        end else if (mode.zero) begin
            stat.exhausted  = (pos >= vlen);
            sel             = pos[IW-1:0];
            stat.masked_off = (pos < vlen) && !mask[pos[IW-1:0]];
            nxt             = pos + CW'(1);
        end else begin
            stat.exhausted = !any_elig;
            sel            = low_idx;
            nxt            = CW'(low_idx) + CW'(1);
        end
    end

endmodule

// File: rtl/tpseq_step_seq.sv
// Twin-masked element pair sequencer (top).
module tpseq_step_seq
    import tpseq_pkg::*;
#(
    parameter  int N  = 8,
    localparam int IW = $clog2(N),
    localparam int CW = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [CW-1:0] vl,
    input  logic [N-1:0]  src_mask,
    input  logic [N-1:0]  dst_mask,
    input  logic          src_zero,
    input  logic          dst_zero,
    input  logic          src_scalar,
    input  logic          dst_scalar,
    input  logic          out_ready,
    output logic          out_valid,
    output logic [IW-1:0] src_idx,
    output logic [IW-1:0] dst_idx,
    output logic          src_null,
    output logic          zero_wr,
    output logic          done
);

    seq_state_e    st_q;
    logic          busy;
    logic [N-1:0]  smask_q, dmask_q;
    logic [CW-1:0] vl_q, spos_q, dpos_q;
    side_mode_t    smode_q, dmode_q;

    side_stat_t    s_stat, d_stat;
    logic [IW-1:0] s_sel, d_sel;
    logic [CW-1:0] s_nxt, d_nxt;
    logic [CW-1:0] vl_clamped;
    logic          fire;

    assign busy       = (st_q == SEQ_RUN);
    assign vl_clamped = (vl > CW'(N)) ? CW'(N) : vl;

    tpseq_side_scan #(.N(N), .IS_DST(1'b0)) u_src (
        .mask (smask_q),
        .vlen (vl_q),
        .pos  (spos_q),
        .mode (smode_q),
        .stat (s_stat),
        .sel  (s_sel),
        .nxt  (s_nxt)
    );

    tpseq_side_scan #(.N(N), .IS_DST(1'b1)) u_dst (
        .mask (dmask_q),
        .vlen (vl_q),
        .pos  (dpos_q),
        .mode (dmode_q),
        .stat (d_stat),
        .sel  (d_sel),
        .nxt  (d_nxt)
    );

    assign out_valid = busy && !s_stat.exhausted && !d_stat.exhausted;
    assign done      = busy && (s_stat.exhausted || d_stat.exhausted);
    assign src_idx   = s_sel;
    assign dst_idx   = d_sel;
    assign src_null  = out_valid && s_stat.masked_off;
    assign zero_wr   = out_valid && d_stat.masked_off;
    assign fire      = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= SEQ_IDLE;
            smask_q <= '0;
            dmask_q <= '0;
            vl_q    <= '0;
            smode_q <= '0;
            dmode_q <= '0;
            spos_q  <= '0;
            dpos_q  <= '0;
        end else begin
            case (st_q)
                SEQ_IDLE: begin
                    if (start) begin
                        st_q         <= SEQ_RUN;
                        smask_q      <= src_mask;
                        dmask_q      <= dst_mask;
                        vl_q         <= vl_clamped;
                        smode_q.zero   <= src_zero;
                        smode_q.scalar <= src_scalar;
                        dmode_q.zero   <= dst_zero;
                        dmode_q.scalar <= dst_scalar;
                        spos_q       <= '0;
                        dpos_q       <= '0;
                    end
                end
                default: begin
                    if (done) begin
                        st_q <= SEQ_IDLE;
                    end else if (fire) begin
                        spos_q <= s_nxt;
                        dpos_q <= d_nxt;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/tpseq_checker.sv
// Protocol and ordering checks for tpseq_step_seq, attached by bind.
module tpseq_checker #(
    parameter  int N  = 8,
    localparam int IW = $clog2(N)
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          src_zero,
    input logic          dst_zero,
    input logic          src_scalar,
    input logic          dst_scalar,
    input logic          out_valid,
    input logic          out_ready,
    input logic [IW-1:0] src_idx,
    input logic [IW-1:0] dst_idx,
    input logic          src_null,
    input logic          zero_wr,
    input logic          done
);

    logic          have_q;
    logic [IW-1:0] last_s_q, last_d_q;

    always_ff @(posedge clk) begin
        if (rst || !busy) begin
            have_q   <= 1'b0;
            last_s_q <= '0;
            last_d_q <= '0;
        end else if (out_valid && out_ready) begin
            have_q   <= 1'b1;
            last_s_q <= src_idx;
            last_d_q <= dst_idx;
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!out_valid && !done));

    p_src_ascend_r2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && have_q && !src_scalar) |-> (src_idx > last_s_q));

    p_dst_ascend_r3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && have_q && !dst_scalar) |-> (dst_idx > last_d_q));

    p_zero_wr_src_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && zero_wr) |-> dst_zero);

    p_src_null_src_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && src_null) |-> src_zero);

    p_src_scalar_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && src_scalar) |-> (src_idx == '0 && !src_null));

    p_dst_scalar_idx_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && dst_scalar) |-> (dst_idx == '0));

    p_dst_scalar_once_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && dst_scalar) |=> !out_valid);

    p_done_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && done));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !out_valid));

    p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(src_idx) && $stable(dst_idx)));

endmodule

bind tpseq_step_seq tpseq_checker #(.N(N)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .src_zero   (smode_q.zero),
    .dst_zero   (dmode_q.zero),
    .src_scalar (smode_q.scalar),
    .dst_scalar (dmode_q.scalar),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .src_idx    (src_idx),
    .dst_idx    (dst_idx),
    .src_null   (src_null),
    .zero_wr    (zero_wr),
    .done       (done)
);

// File: tb/tpseq_step_seq_bench.sv
`timescale 1ns/1ps
module tpseq_step_seq_bench;

    localparam int N  = 4;
    localparam int IW = 2;
    localparam int CW = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic [CW-1:0] vl;
    logic [N-1:0]  src_mask, dst_mask;
    logic          src_zero, dst_zero, src_scalar, dst_scalar;
    logic          out_ready;
    logic          out_valid;
    logic [IW-1:0] src_idx, dst_idx;
    logic          src_null, zero_wr, done;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    // expected pair lists
    int exp_s [N+1];
    int exp_d [N+1];
    bit exp_n [N+1];
    bit exp_z [N+1];

    always #5 clk = ~clk;

    tpseq_step_seq #(.N(N)) u_tpseq_step_seq (
        .clk(clk), .rst(rst), .start(start), .vl(vl),
        .src_mask(src_mask), .dst_mask(dst_mask),
        .src_zero(src_zero), .dst_zero(dst_zero),
        .src_scalar(src_scalar), .dst_scalar(dst_scalar),
        .out_ready(out_ready), .out_valid(out_valid),
        .src_idx(src_idx), .dst_idx(dst_idx),
        .src_null(src_null), .zero_wr(zero_wr), .done(done)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic string mode_tag(input int v, input bit sz, input bit dz,
                                       input bit ss, input bit ds);
        if (v > N)   return "R10 clamp pair";
        if (ss)      return "R6 scalar source pair";
        if (ds)      return "R7 scalar destination pair";
        if (sz || dz) return "R5 zeroing pair";
        return "R2/R3/R4 pair";
    endfunction

    task automatic step_lfsr();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    task automatic run(input int v, input logic [N-1:0] ms, input logic [N-1:0] md,
                       input bit sz, input bit dz, input bit ss, input bit ds);
        int veff, ls, ld, cnt, n;
        bit got_done, stalled;
        int hold_s, hold_d;
        string tag;
        veff = (v > N) ? N : v;
        ls = 0; ld = 0;
        for (int i = 0; i <= N; i++) begin
            exp_s[i] = 0; exp_d[i] = 0; exp_n[i] = 0; exp_z[i] = 0;
        end
        if (ss) ls = N + 1;
        else for (int i = 0; i < veff; i++) begin
            if (sz) begin exp_s[ls] = i; exp_n[ls] = !ms[i]; ls++; end
            else if (ms[i]) begin exp_s[ls] = i; ls++; end
        end
        if (ds) ld = 1;
        else for (int i = 0; i < veff; i++) begin
            if (dz) begin exp_d[ld] = i; exp_z[ld] = !md[i]; ld++; end
            else if (md[i]) begin exp_d[ld] = i; ld++; end
        end
        cnt = (veff == 0) ? 0 : ((ls < ld) ? ls : ld);
        tag = mode_tag(v, sz, dz, ss, ds);

        @(negedge clk);
        vl = CW'(v); src_mask = ms; dst_mask = md;
        src_zero = sz; dst_zero = dz; src_scalar = ss; dst_scalar = ds;
        start = 1'b1; out_ready = 1'b0;

        n = 0; got_done = 0; stalled = 0; hold_s = 0; hold_d = 0;
        for (int k = 0; k < 40 && !got_done; k++) begin
            @(negedge clk);
            if (k == 0)
                check(out_valid || done, "R1 response one cycle after start", int'(out_valid), 1);
            if (out_valid && done)
                check(0, "R8 valid and done together", 1, 0);
            if (stalled) begin
                check(out_valid && int'(src_idx) == hold_s && int'(dst_idx) == hold_d,
                      "R9 pair held during stall", int'(src_idx), hold_s);
            end
            if (done) begin
                check(n == cnt, "R4/R8/R10 pairs accepted at done", n, cnt);
                got_done = 1;
            end else if (out_valid) begin
                if (n >= cnt) check(0, {tag, " extra pair"}, n, cnt);
                else begin
                    check(int'(src_idx) == exp_s[n], {tag, " src_idx"}, int'(src_idx), exp_s[n]);
                    check(int'(dst_idx) == exp_d[n], {tag, " dst_idx"}, int'(dst_idx), exp_d[n]);
                    check(src_null == exp_n[n], {tag, " src_null"}, int'(src_null), int'(exp_n[n]));
                    check(zero_wr == exp_z[n], {tag, " zero_wr"}, int'(zero_wr), int'(exp_z[n]));
                end
            end
            // drive the next edge; R10: scramble inputs and pulse start while busy
            step_lfsr();
            out_ready = lfsr[0] | lfsr[1];
            stalled = out_valid && !done && !out_ready;
            hold_s = int'(src_idx); hold_d = int'(dst_idx);
            if (out_valid && !done && out_ready) n++;
            start = !done && lfsr[2] && lfsr[3];
            src_mask = lfsr[7:4]; dst_mask = lfsr[11:8];
            vl = lfsr[14:12];
            src_zero = lfsr[3]; dst_zero = lfsr[5];
            src_scalar = lfsr[9]; dst_scalar = lfsr[6];
        end
        if (!got_done) check(0, "R8 done never seen", 0, 1);
        @(negedge clk);
        check(!out_valid && !done, "R8 single-cycle done then idle", int'(done), 0);
        start = 1'b0;
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; vl = '0; src_mask = '0; dst_mask = '0;
        src_zero = 0; dst_zero = 0; src_scalar = 0; dst_scalar = 0; out_ready = 0;
        repeat (3) @(negedge clk);
        check(!out_valid && !done, "R1 reset state", int'(out_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        check(!out_valid && !done, "R1 idle after reset", int'(done), 0);

        // plain vector runs over every length including clamped ones (R2, R3, R4, R8, R10)
        for (int v = 0; v < 8; v++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++)
                    run(v, N'(a), N'(b), 0, 0, 0, 0);

        // every zeroing/scalar mode at full length (R5, R6, R7)
        for (int m = 1; m < 16; m++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++)
                    run(N, N'(a), N'(b), m[0], m[1], m[2], m[3]);

        // zeroing and scalar modes at a short length
        for (int m = 1; m < 16; m++)
            for (int a = 0; a < 16; a++)
                run(2, N'(a), N'(15 - a), m[0], m[1], m[2], m[3]);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule